// File: doc/BRIEF.md
# Breathing LED PWM controller

This block drives one LED with a pulse-width modulated signal. An up-counter advances on each pulse of a PWM clock-enable tick. It wraps at a value picked by a resolution field. While the counter is below a duty value, the LED is lit. In the fixed-duty mode, the duty is the low byte of a limits register. In the breathing mode, a small ramp engine moves the duty between a low and a high limit, one step at a time. It holds at each end for a programmed number of PWM periods.

Software reaches five 32-bit registers through a word-addressed bus with byte enables. Writes to the configuration register act on the next clock. The limits, hold-delay, step-size and step-interval registers are each double-buffered. A write lands in a holding copy. The holding copy moves into the operating copy only when a PWM period ends. The limits always move at that point. The three ramp-shape registers move only when software has set a commit bit in the configuration register. This lets a ramp change built from several narrow writes take effect in a single period. Reads return the configuration register and the holding copies.

Top module: `led_breath_pwm`

## Requirements
- R1: The counter advances by one on each clock that has `pwm_tick` high, and holds otherwise. Configuration bits [3:2] pick its wrap value: 00 gives 255, 01 gives 254, 10 gives 252 and 11 gives 255. A tick that finds the counter at or above the wrap value sends it to 0 and ends a PWM period. So the period lasts 256, 255, 253 or 256 ticks.
- R2: A write to the configuration register (word 0) changes the LED behaviour from the next clock.
- R3: A write to the limits register (word 1; [7:0] low/duty, [15:8] high) changes only its holding copy. That copy becomes the operating copy at every period end, whatever the commit bit says. A write in the same clock as a period end reaches the operating copy one period later.
- R4: Writes to the hold-delay (word 2; [7:0] at low, [15:8] at high), step-size (word 3; [7:0] rising, [15:8] falling) and step-interval (word 4; same split) registers change only their holding copies. These are copied at a period end only while the commit bit (configuration bit 6) is 1, and that copy clears the commit bit. A write to configuration byte 0 in that same clock sets the bit to the written value instead. With the commit bit at 0, the holding copies keep their contents.
- R5: Each byte lane is written only when its `bus_be` bit is 1. Other bytes keep their value.
- R6: Writing configuration byte 0 with bit 7 set returns every register, the counter and the ramp to their reset values: configuration 0x0000_1400, all others 0. Bit 7 always reads 0. Writing it as 0 resets nothing.
- R7: Word 0 reads the configuration register, with bits [31:17], [5:4] and 7 reading 0. Words 1 to 4 read their holding copies in bits [15:0], with the upper bits reading 0. Words 5 to 7 read 0.
- R8: Configuration bits [1:0] pick the LED mode. 00 is always dark and 01 is always lit. In 10 the LED is lit while the counter is below the operating low limit. In 11 it is lit while the counter is below the ramp duty.
- R9: In breathing mode the ramp acts only at period ends. It first holds the duty at the low limit until the low-hold count of extra periods has passed. It then rises by the rising step after each (interval+1) periods, clamping at the high limit. It holds there for (high-hold+1) periods, then falls by the falling step and clamps at the low limit. The cycle then repeats. Outside breathing mode the duty follows the operating low limit.
- R10: Configuration bit 16 set makes the falling side use the upper bytes of the step-size and step-interval registers. Clear, both sides use the lower bytes.
- R11: Configuration bits [15:8] are a read/write watchdog reload field whose reset value is 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| pwm_tick | input | 1 | Clock enable for the PWM counter |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW (3) | Word address of the register |
| bus_be | input | 4 | Byte enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| led_out | output | 1 | LED drive, high means lit |

## Verification
The bench measures the period length at each resolution setting from the spacing of single-tick LED pulses. A wrong wrap value would shift that spacing by one or more ticks. It writes ramp registers without committing and confirms that the holding copy survives several periods while the ramp stays unchanged. It then commits and checks that the commit bit clears itself. A design that copied without the bit, or never cleared it, would breathe with early parameters or re-apply them. Long randomized runs switch resolution while the counter is above the new wrap value, write partial byte lanes, land writes on period ends, and issue occasional soft resets. The bench compares every cycle against its own model, so a lost wrap, a torn byte lane or a copy one period late shows up as an LED or read-data mismatch.

// File: rtl/lpwm_pkg.sv
package lpwm_pkg;

  localparam int unsigned LPWM_FW = 8;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_ON     = 2'd1,
    MODE_PWM    = 2'd2,
    MODE_BREATH = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    RMP_LOW  = 2'd0,
    RMP_RISE = 2'd1,
    RMP_HIGH = 2'd2,
    RMP_FALL = 2'd3
  } ramp_e;

  typedef struct packed {
    logic [LPWM_FW-1:0] hi;
    logic [LPWM_FW-1:0] lo;
  } pair_t;

  // Word indices of the register file.
  localparam int unsigned IDX_CFG = 0;
  localparam int unsigned IDX_LIM = 1;
  localparam int unsigned NUM_SHADOW = 4;

  // Configuration register layout.
  localparam int unsigned CFG_UPD_BIT  = 6;
  localparam int unsigned CFG_SOFT_BIT = 7;
  localparam int unsigned CFG_ASYM_BIT = 16;
  localparam logic [31:0] CFG_RW_MASK  = 32'h0001_FF4F;
  localparam logic [31:0] CFG_DEFAULT  = 32'h0000_1400;

endpackage

// File: rtl/lpwm_counter.sv
module lpwm_counter
  import lpwm_pkg::*;
#(
  parameter int unsigned CW = LPWM_FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [1:0]    res,
  output logic [CW-1:0] cnt,
  output logic          period_end
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  logic [CW-1:0] wrap;
  logic [CW-1:0] cnt_d;

  always_comb begin
    unique case (res)
      2'd1:    wrap = TOP - CW'(1);
      2'd2:    wrap = TOP - CW'(3);
      default: wrap = TOP;
    endcase
  end

  // At-or-above, so a resolution drop with the count past the new top still wraps.
  assign period_end = tick && (cnt >= wrap);

  always_comb begin
    cnt_d = cnt;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = period_end ? '0 : cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && cnt >= wrap) |=> (cnt == '0));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));

endmodule

// File: rtl/lpwm_regs.sv
module lpwm_regs
  import lpwm_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          period_end,
  output logic          soft_rst,
  output mode_e         mode,
  output logic [1:0]    res,
  output logic          asym,
  output pair_t         lim_op,
  output pair_t         dly_op,
  output pair_t         stp_op,
  output pair_t         ivl_op
);

  localparam int unsigned PW = 2 * LPWM_FW;

  logic [31:0] wmask;
  logic        hit_cfg;
  logic [31:0] cfg_q, cfg_d;
  logic [PW-1:0] sh_all [NUM_SHADOW];
  logic [PW-1:0] op_all [NUM_SHADOW];

  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign wmask[8*b +: 8] = {8{bus_be[b]}};
  end

  assign hit_cfg  = bus_wr && (bus_addr == AW'(IDX_CFG));
  assign soft_rst = hit_cfg && bus_be[0] && bus_wdata[CFG_SOFT_BIT];

  // Configuration: hardware clears the commit bit after a copy; a write wins.
  always_comb begin
    cfg_d = cfg_q;
    if (period_end && cfg_q[CFG_UPD_BIT]) cfg_d[CFG_UPD_BIT] = 1'b0;
    if (hit_cfg) cfg_d = ((cfg_d & ~wmask) | (bus_wdata & wmask)) & CFG_RW_MASK;
    if (soft_rst) cfg_d = CFG_DEFAULT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_DEFAULT;
    else        cfg_q <= cfg_d;
  end

  // Holding / operating pairs. Entry 0 (limits) copies every period,
  // the rest only under the commit bit.
  for (genvar k = 0; k < NUM_SHADOW; k++) begin : g_shadow
    localparam bit COPY_ALWAYS = (k == 0);
    logic          hit;
    logic          copy;
    logic [PW-1:0] sh_q, sh_d, op_q, op_d;

    assign hit  = bus_wr && (bus_addr == AW'(k + 1));
    assign copy = period_end && (COPY_ALWAYS || cfg_q[CFG_UPD_BIT]);

    always_comb begin
      sh_d = sh_q;
      op_d = op_q;
      if (copy) op_d = sh_q;
      if (hit)  sh_d = (sh_q & ~wmask[PW-1:0]) | (bus_wdata[PW-1:0] & wmask[PW-1:0]);
      if (soft_rst) begin
        sh_d = '0;
        op_d = '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '0;
        op_q <= '0;
      end else begin
        sh_q <= sh_d;
        op_q <= op_d;
      end
    end

    assign sh_all[k] = sh_q;
    assign op_all[k] = op_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(IDX_CFG)) bus_rdata = cfg_q;
    for (int k = 0; k < NUM_SHADOW; k++) begin
      if (bus_addr == AW'(k + 1)) bus_rdata = {{(32-PW){1'b0}}, sh_all[k]};
    end
  end

  assign mode   = mode_e'(cfg_q[1:0]);
  assign res    = cfg_q[3:2];
  assign asym   = cfg_q[CFG_ASYM_BIT];
  assign lim_op = pair_t'(op_all[IDX_LIM-1]);
  assign dly_op = pair_t'(op_all[1]);
  assign stp_op = pair_t'(op_all[2]);
  assign ivl_op = pair_t'(op_all[3]);

  p_lim_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_end && !soft_rst) |=> $stable(op_all[0]));

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(period_end && cfg_q[CFG_UPD_BIT]) && !soft_rst) |=> $stable(op_all[2]));

  p_commit_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && cfg_q[CFG_UPD_BIT] && !hit_cfg) |=> !cfg_q[CFG_UPD_BIT]);

  p_soft_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cfg_q == CFG_DEFAULT && op_all[0] == '0));

endmodule

// File: rtl/lpwm_ramp.sv
module lpwm_ramp
  import lpwm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               active,
  input  logic               period_end,
  input  logic               asym,
  input  pair_t              lim,
  input  pair_t              dly,
  input  pair_t              stp,
  input  pair_t              ivl,
  output logic [LPWM_FW-1:0] duty
);

  localparam int unsigned FW = LPWM_FW;

  ramp_e         state_q, state_d;
  logic [FW-1:0] duty_q, duty_d;
  logic [FW-1:0] wait_q, wait_d;
  logic [FW-1:0] step_up, step_dn, ivl_up, ivl_dn;
  logic [FW:0]   sum_up, floor_dn;

  assign step_up  = stp.lo;
  assign ivl_up   = ivl.lo;
  assign step_dn  = asym ? stp.hi : stp.lo;
  assign ivl_dn   = asym ? ivl.hi : ivl.lo;
  assign sum_up   = {1'b0, duty_q} + {1'b0, step_up};
  assign floor_dn = {1'b0, lim.lo} + {1'b0, step_dn};

  always_comb begin
    state_d = state_q;
    duty_d  = duty_q;
    wait_d  = wait_q;
    if (clr) begin
      state_d = RMP_LOW;
      duty_d  = '0;
      wait_d  = '0;
    end else if (!active) begin
      state_d = RMP_LOW;
      duty_d  = lim.lo;
      wait_d  = '0;
    end else if (period_end) begin
      unique case (state_q)
        RMP_LOW: begin
          if (wait_q >= dly.lo) begin
            state_d = RMP_RISE;
            wait_d  = '0;
          end else begin
            wait_d = wait_q + FW'(1);
          end
        end
        RMP_RISE: begin
          if (wait_q >= ivl_up) begin
            wait_d = '0;
            if (sum_up >= {1'b0, lim.hi}) begin
              duty_d  = lim.hi;
              state_d = RMP_HIGH;
            end else begin
              duty_d = sum_up[FW-1:0];
            end
          end else begin
            wait_d = wait_q + FW'(1);
          end
        end
        RMP_HIGH: begin
          if (wait_q >= dly.hi) begin
            state_d = RMP_FALL;
            wait_d  = '0;
          end else begin
            wait_d = wait_q + FW'(1);
          end
        end
        default: begin
          if (wait_q >= ivl_dn) begin
            wait_d = '0;
            if ({1'b0, duty_q} <= floor_dn) begin
              duty_d  = lim.lo;
              state_d = RMP_LOW;
            end else begin
              duty_d = duty_q - step_dn;
            end
          end else begin
            wait_d = wait_q + FW'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RMP_LOW;
      duty_q  <= '0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      duty_q  <= duty_d;
      wait_q  <= wait_d;
    end
  end

  assign duty = duty_q;

  p_idle_duty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clr) |=> (duty == $past(lim.lo)));

  p_duty_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !period_end && !clr) |=> $stable(duty));

endmodule

// File: rtl/led_breath_pwm.sv
module led_breath_pwm
  import lpwm_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwm_tick,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          led_out
);

  logic [1:0]         rst_pipe;
  logic               rst_core;
  logic               soft_rst;
  logic               period_end;
  logic [LPWM_FW-1:0] cnt;
  logic [LPWM_FW-1:0] duty;
  logic [1:0]         res;
  logic               asym;
  mode_e              mode;
  pair_t              lim_op, dly_op, stp_op, ivl_op;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core = rst_pipe[1];

  lpwm_regs #(.AW(AW)) i_regs (
    .clk        (clk),
    .rst_n      (rst_core),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .period_end (period_end),
    .soft_rst   (soft_rst),
    .mode       (mode),
    .res        (res),
    .asym       (asym),
    .lim_op     (lim_op),
    .dly_op     (dly_op),
    .stp_op     (stp_op),
    .ivl_op     (ivl_op)
  );

  lpwm_counter #(.CW(LPWM_FW)) i_counter (
    .clk        (clk),
    .rst_n      (rst_core),
    .clr        (soft_rst),
    .tick       (pwm_tick),
    .res        (res),
    .cnt        (cnt),
    .period_end (period_end)
  );

  lpwm_ramp i_ramp (
    .clk        (clk),
    .rst_n      (rst_core),
    .clr        (soft_rst),
    .active     (mode == MODE_BREATH),
    .period_end (period_end),
    .asym       (asym),
    .lim        (lim_op),
    .dly        (dly_op),
    .stp        (stp_op),
    .ivl        (ivl_op),
    .duty       (duty)
  );

  always_comb begin
    unique case (mode)
      MODE_OFF: led_out = 1'b0;
      MODE_ON:  led_out = 1'b1;
      MODE_PWM: led_out = (cnt < lim_op.lo);
      default:  led_out = (cnt < duty);
    endcase
  end

  p_on_r2: assert property (@(posedge clk) disable iff (!rst_core)
    (bus_wr && bus_addr == AW'(IDX_CFG) && bus_be[0] &&
     bus_wdata[1:0] == 2'b01 && !bus_wdata[CFG_SOFT_BIT]) |=> led_out);

endmodule

// File: tb/test_led_breath_pwm.sv
`timescale 1ns/1ps
module test_led_breath_pwm;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pwm_tick;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        led_out;

  always #2 clk = ~clk;

  led_breath_pwm #(.AW(3)) i_led_breath_pwm (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .led_out(led_out)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic        last_led;
  logic [31:0] last_rd;

  // Reference model state.
  logic [31:0] m_cfg;
  logic [15:0] m_sh [4];
  logic [15:0] m_op [4];
  logic [7:0]  m_cnt, m_duty, m_wait;
  logic [1:0]  m_st;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_defaults();
    m_cfg = 32'h0000_1400;
    for (int k = 0; k < 4; k++) begin
      m_sh[k] = '0;
      m_op[k] = '0;
    end
    m_cnt = '0; m_duty = '0; m_wait = '0; m_st = 2'd0;
  endtask

  function automatic logic [7:0] m_wrap(input logic [1:0] r);
    case (r)
      2'd1:    return 8'hFE;
      2'd2:    return 8'hFC;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    if (a == 3'd0) return m_cfg;
    if (a >= 3'd1 && a <= 3'd4) return {16'h0, m_sh[a-1]};
    return 32'h0;
  endfunction

  function automatic logic m_led();
    case (m_cfg[1:0])
      2'd0:    return 1'b0;
      2'd1:    return 1'b1;
      2'd2:    return m_cnt < m_op[0][7:0];
      default: return m_cnt < m_duty;
    endcase
  endfunction

  function automatic logic [15:0] merge16(input logic [15:0] o, input logic [31:0] w, input logic [3:0] be);
    logic [15:0] r;
    r = o;
    if (be[0]) r[7:0]  = w[7:0];
    if (be[1]) r[15:8] = w[15:8];
    return r;
  endfunction

  task automatic m_step(input logic wr, input logic [2:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input logic tk);
    logic pe, upd, asy;
    logic [31:0] ncfg;
    logic [7:0] ncnt, nduty, nwait, lo, hi, su, sd, iu, id;
    logic [1:0] nst;
    logic [8:0] sum, flo;
    logic [15:0] nsh [4];
    logic [15:0] nop [4];
    if (wr && a == 3'd0 && be[0] && wd[7]) begin
      m_defaults();
      return;
    end
    pe   = tk && (m_cnt >= m_wrap(m_cfg[3:2]));
    ncnt = tk ? (pe ? 8'h00 : m_cnt + 8'd1) : m_cnt;
    upd  = m_cfg[6];
    asy  = m_cfg[16];
    lo = m_op[0][7:0]; hi = m_op[0][15:8];
    su = m_op[2][7:0]; sd = asy ? m_op[2][15:8] : m_op[2][7:0];
    iu = m_op[3][7:0]; id = asy ? m_op[3][15:8] : m_op[3][7:0];
    nst = m_st; nduty = m_duty; nwait = m_wait;
    if (m_cfg[1:0] != 2'd3) begin
      nst = 2'd0; nduty = lo; nwait = '0;
    end else if (pe) begin
      case (m_st)
        2'd0: if (m_wait >= m_op[1][7:0]) begin nst = 2'd1; nwait = 0; end else nwait = m_wait + 1;
        2'd1: if (m_wait >= iu) begin
                nwait = 0; sum = {1'b0, m_duty} + {1'b0, su};
                if (sum >= {1'b0, hi}) begin nduty = hi; nst = 2'd2; end else nduty = sum[7:0];
              end else nwait = m_wait + 1;
        2'd2: if (m_wait >= m_op[1][15:8]) begin nst = 2'd3; nwait = 0; end else nwait = m_wait + 1;
        default: if (m_wait >= id) begin
                nwait = 0; flo = {1'b0, lo} + {1'b0, sd};
                if ({1'b0, m_duty} <= flo) begin nduty = lo; nst = 2'd0; end else nduty = m_duty - sd;
              end else nwait = m_wait + 1;
      endcase
    end
    for (int k = 0; k < 4; k++) begin
      nop[k] = m_op[k];
      if (pe && (k == 0 || upd)) nop[k] = m_sh[k];
      nsh[k] = (wr && a == 3'(k + 1)) ? merge16(m_sh[k], wd, be) : m_sh[k];
    end
    ncfg = m_cfg;
    if (pe && upd) ncfg[6] = 1'b0;
    if (wr && a == 3'd0) begin
      for (int b = 0; b < 4; b++) if (be[b]) ncfg[8*b +: 8] = wd[8*b +: 8];
      ncfg = ncfg & 32'h0001_FF4F;
    end
    m_cfg = ncfg; m_cnt = ncnt; m_duty = nduty; m_wait = nwait; m_st = nst;
    for (int k = 0; k < 4; k++) begin
      m_sh[k] = nsh[k];
      m_op[k] = nop[k];
    end
  endtask

  function automatic string led_tag();
    if (m_cfg[1:0] == 2'd3) return m_cfg[16] ? "R9 R10 breathing led" : "R9 breathing led";
    return "R8 led mode";
  endfunction

  // One clock: drive at the falling edge, compare, step the model at the rising edge.
  task automatic cyc(input logic wr, input logic [2:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic tk);
    bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = wd; pwm_tick = tk;
    #1;
    chk("R7 read data", bus_rdata, m_read(a));
    chk(led_tag(), {31'b0, led_out}, {31'b0, m_led()});
    last_led = led_out;
    last_rd  = bus_rdata;
    @(posedge clk);
    m_step(wr, a, be, wd, tk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
  endtask

  task automatic gap(output int g);
    int first;
    first = -1;
    g = -1;
    for (int i = 0; i < 1200; i++) begin
      cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
      if (last_led) begin
        if (first < 0) first = i;
        else begin
          g = i - first;
          break;
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 190000; i++) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int g;
    int lit;
    void'($urandom(32'd4242));
    m_defaults();
    rst_n = 1'b0; pwm_tick = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset values.
    cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b0);
    chk("R11 watchdog reload reset value", last_rd, 32'h0000_1400);
    for (int k = 1; k < 8; k++) begin
      cyc(1'b0, 3'(k), 4'h0, 32'h0, 1'b0);
      chk("R7 reset read of word", last_rd, 32'h0);
    end

    // R2: mode change acts next clock.
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_1401, 1'b1);
    cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
    chk("R2 led lit after mode write", {31'b0, last_led}, 32'h1);

    // R5 / R11: single lane write.
    cyc(1'b1, 3'd0, 4'b0010, 32'hFFFF_FFFF, 1'b1);
    cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
    chk("R5 R11 byte lane 1 only", last_rd, 32'h0000_FF01);
    cyc(1'b1, 3'd0, 4'b0010, 32'h0000_1400, 1'b1);

    // R1: period length per resolution, LED lit only at count 0.
    cyc(1'b1, 3'd1, 4'b0001, 32'h0000_0001, 1'b1);
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_000A, 1'b1);
    gap(g); chk("R1 period with res 10", 32'(g), 32'd253);
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_0006, 1'b1);
    gap(g); gap(g); chk("R1 period with res 01", 32'(g), 32'd255);
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_0002, 1'b1);
    gap(g); gap(g); chk("R1 period with res 00", 32'(g), 32'd256);
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_000E, 1'b1);
    gap(g); gap(g); chk("R1 period with res 11", 32'(g), 32'd256);

    // R3: holding readback, then duty after copy.
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_0002, 1'b1);
    cyc(1'b1, 3'd1, 4'b0001, 32'h0000_0040, 1'b1);
    cyc(1'b0, 3'd1, 4'h0, 32'h0, 1'b1);
    chk("R3 limits holding readback", last_rd, 32'h0000_0040);
    idle(300);
    lit = 0;
    for (int i = 0; i < 256; i++) begin
      cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
      lit += int'(last_led);
    end
    chk("R3 R8 lit count per period", 32'(lit), 32'd64);

    // R4: holding kept without commit; commit clears itself.
    cyc(1'b1, 3'd2, 4'b0011, 32'h0000_0302, 1'b1);
    idle(600);
    cyc(1'b0, 3'd2, 4'h0, 32'h0, 1'b1);
    chk("R4 delay holding retained", last_rd, 32'h0000_0302);
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_0042, 1'b1);
    cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b0);
    chk("R4 commit bit set", last_rd, 32'h0000_1442);
    idle(300);
    cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
    chk("R4 commit bit cleared after copy", last_rd, 32'h0000_1402);

    // R9 / R10: asymmetric breathing, checked every cycle against the model.
    cyc(1'b1, 3'd1, 4'b0011, 32'h0000_4010, 1'b1);
    cyc(1'b1, 3'd3, 4'b0011, 32'h0000_0810, 1'b1);
    cyc(1'b1, 3'd4, 4'b0011, 32'h0000_0100, 1'b1);
    cyc(1'b1, 3'd2, 4'b0011, 32'h0000_0201, 1'b1);
    cyc(1'b1, 3'd0, 4'b0111, 32'h0001_1443, 1'b1);
    idle(15400);
    cyc(1'b1, 3'd0, 4'b0101, 32'h0000_0043, 1'b1);
    idle(8000);

    // R6: soft reset and the no-effect zero write.
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_0080, 1'b1);
    cyc(1'b0, 3'd0, 4'h0, 32'h0, 1'b1);
    chk("R6 config after soft reset", last_rd, 32'h0000_1400);
    cyc(1'b0, 3'd1, 4'h0, 32'h0, 1'b1);
    chk("R6 limits after soft reset", last_rd, 32'h0);
    cyc(1'b1, 3'd1, 4'b0001, 32'h0000_0055, 1'b1);
    cyc(1'b1, 3'd0, 4'b0001, 32'h0000_0001, 1'b1);
    cyc(1'b0, 3'd1, 4'h0, 32'h0, 1'b1);
    chk("R6 zero bit 7 keeps limits", last_rd, 32'h0000_0055);

    // Random mix.
    for (int i = 0; i < 50000; i++) begin
      logic [2:0]  a;
      logic [31:0] wd;
      a  = 3'($urandom % 7);
      wd = $urandom;
      if (a == 3'd0) wd[7] = (($urandom % 300) == 0);
      if (a == 3'd2 || a == 3'd4) wd = wd & 32'h0000_0707;
      if (a == 3'd3) wd = wd & 32'h0000_3F3F;
      cyc((($urandom % 6) == 0), a, 4'($urandom % 16), wd, (($urandom % 4) != 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule